// File: doc/BRIEF.md
# Fractional MND Root Clock Generator

This block produces a root clock from one of several source clocks. Each source arrives as an edge strobe, one system-clock-wide pulse per source clock edge, rising or falling. The chosen source first passes through a pre-divider whose setting moves in half steps, so it can divide by 1, 1.5, 2, 2.5 and so on. The divided clock can then go through an M/N accumulator stage. That stage yields M output periods for every N divided periods, and the high time is set by a D value. Every path in the block runs on the system clock, and the output is a registered level.

Software programs a configuration word and the M, N and D values through a small write and read port. These writes go only to shadow copies. A write of 1 to bit 0 of the command register requests an update. The hardware copies the shadow set into the active set at the first system clock in which the output is low, then clears the bit. Software polls that bit to learn when the update has been applied.

For example, an 800 MHz source with a pre-divide of 4 or 8 and the accumulator bypassed gives 200 MHz or 100 MHz. With divide 1, M=144 and N=15625, the output averages 7.3728 MHz.

Top module: `mnd_root_clkgen`

## Requirements
- R1: After reset the output is low, and reads of all five registers return 0. The registers are at address 0 (command), 1 (configuration), 2 (M), 3 (N) and 4 (D). Read data is registered and appears one cycle after the address.
- R2: Only configuration bits [13:0] are stored. A write of all ones reads back as 0x3FFF.
- R3: Writes to the configuration, M, N and D registers leave the output waveform unchanged until an update is applied.
- R4: A write to address 0 with bit 0 set makes bit 0 read 1. The bit clears in the same cycle that the shadow values become active, which is the first cycle the output is low. A write with bit 0 clear has no effect.
- R5: Divider field bits [4:0] = f sets an output period of f+1 source edges, and f=0 acts like f=1. After an update the output goes high on the first selected edge and stays high for floor((f+1)/2) edges of each period.
- R6: Source field bits [10:8] selects which strobe advances the generator, and strobes from other sources leave the output unchanged. A value at or above the number of sources stops the output.
- R7: Accumulator mode is on only when mode bits [13:12] = 2 and the N register is nonzero. N equals the inverse of the N register plus M, modulo 2^16. In divided period j (numbered from 0 after an update), a wrap occurs when floor((j+1)M/N) > floor(jM/N). Every other setting divides only.
- R8: In accumulator mode the output is high in divided period j when a wrap occurred in one of the last H periods, j included. H is the bitwise inverse of the D register shifted right by one, with a minimum of 1.
- R9: While the output is high, the active settings do not change, so an update never shortens a high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | NUM_SRC | One strobe per source; each pulse is one source edge |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Registered read data |
| clk_out | output | 1 | Generated root clock level |

## Verification
The update handshake and the output edge logic can act in the same system cycle. One case is an update request that arrives together with the source edge that ends a high phase. The other is a request that arrives while the output is high. The bench covers both. It writes the command bit at the same moment it drives the falling edge strobe, and it also writes the command bit in the middle of a high phase and keeps feeding edges. A scoreboard compares every edge's output level against the old settings until the command bit reads 0 and against the new settings after that. Any shortened high phase, or a switch made early, shows up as a level mismatch.

// File: rtl/mnd_clkgen_pkg.sv
package mnd_clkgen_pkg;

  localparam int CFG_W     = 14;
  localparam int DIV_W     = 5;
  localparam int SEL_W     = 3;
  localparam int MODE_W    = 2;
  localparam int DIV_LSB   = 0;
  localparam int SEL_LSB   = 8;
  localparam int MODE_LSB  = 12;
  localparam logic [MODE_W-1:0] MODE_ACCUM = 2'd2;

  typedef enum logic [2:0] {
    REG_CMD  = 3'd0,
    REG_CFG  = 3'd1,
    REG_MVAL = 3'd2,
    REG_NINV = 3'd3,
    REG_DINV = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic [SEL_W-1:0]  sel;
    logic [DIV_W-1:0]  div;
  } root_cfg_t;

endpackage

// File: rtl/mnd_clkgen_regs.sv
module mnd_clkgen_regs
  import mnd_clkgen_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int MND_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              out_low,
  output logic              apply,
  output root_cfg_t         act_cfg,
  output logic [MND_W-1:0]  act_m,
  output logic [MND_W-1:0]  act_ninv,
  output logic [MND_W-1:0]  act_dinv
);

  logic [CFG_W-1:0] sh_cfg;
  logic [MND_W-1:0] sh_m, sh_ninv, sh_dinv;
  logic             pend;
  logic             cmd_wr;

  assign cmd_wr = wr_en && (wr_addr == ADDR_W'(REG_CMD)) && wr_data[0];
  assign apply  = pend && out_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_cfg  <= '0;
      sh_m    <= '0;
      sh_ninv <= '0;
      sh_dinv <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_W'(REG_CFG):  sh_cfg  <= wr_data[CFG_W-1:0];
        ADDR_W'(REG_MVAL): sh_m    <= wr_data[MND_W-1:0];
        ADDR_W'(REG_NINV): sh_ninv <= wr_data[MND_W-1:0];
        ADDR_W'(REG_DINV): sh_dinv <= wr_data[MND_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         pend <= 1'b0;
    else if (cmd_wr) pend <= 1'b1;
    else if (apply)  pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_cfg  <= '0;
      act_m    <= '0;
      act_ninv <= '0;
      act_dinv <= '0;
    end else if (apply) begin
      act_cfg.div  <= sh_cfg[DIV_LSB +: DIV_W];
      act_cfg.sel  <= sh_cfg[SEL_LSB +: SEL_W];
      act_cfg.mode <= sh_cfg[MODE_LSB +: MODE_W];
      act_m        <= sh_m;
      act_ninv     <= sh_ninv;
      act_dinv     <= sh_dinv;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        ADDR_W'(REG_CMD):  rd_data <= DATA_W'(pend);
        ADDR_W'(REG_CFG):  rd_data <= DATA_W'(sh_cfg);
        ADDR_W'(REG_MVAL): rd_data <= DATA_W'(sh_m);
        ADDR_W'(REG_NINV): rd_data <= DATA_W'(sh_ninv);
        ADDR_W'(REG_DINV): rd_data <= DATA_W'(sh_dinv);
        default:           rd_data <= '0;
      endcase
    end
  end

  // R4
  upd_when_low_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pend) |-> $past(out_low));

  // R9
  no_runt_chk: assert property (@(posedge clk) disable iff (rst)
    !out_low |=> ($stable(act_cfg) && $stable(act_m) && $stable(act_ninv) && $stable(act_dinv)));

  // R2
  cfg_width_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_addr) == ADDR_W'(REG_CFG)) |-> (rd_data[DATA_W-1:CFG_W] == '0));

endmodule

// File: rtl/mnd_clkgen_prediv.sv
module mnd_clkgen_prediv
  import mnd_clkgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             tick,
  input  logic [DIV_W-1:0] div_field,
  output logic             start,
  output logic             lvl_nxt
);

  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] period, ec, ec_nxt;
  logic             fresh;

  assign period  = (div_field == '0) ? CNT_W'(2) : CNT_W'(div_field) + CNT_W'(1);
  assign ec_nxt  = (fresh || ec == period - CNT_W'(1)) ? '0 : ec + CNT_W'(1);
  assign start   = tick && (ec_nxt == '0);
  assign lvl_nxt = ec_nxt < (period >> 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ec    <= '0;
      fresh <= 1'b1;
    end else if (restart) begin
      fresh <= 1'b1;
    end else if (tick) begin
      ec    <= ec_nxt;
      fresh <= 1'b0;
    end
  end

  // R5
  ec_bound_chk: assert property (@(posedge clk) disable iff (rst)
    !fresh |-> (ec < period));

endmodule

// File: rtl/mnd_clkgen_accum.sv
module mnd_clkgen_accum #(
  parameter int MND_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             start,
  input  logic [MND_W-1:0] m_val,
  input  logic [MND_W-1:0] n_inv,
  input  logic [MND_W-1:0] d_inv,
  output logic             lvl_nxt
);

  logic [MND_W-1:0] acc, hcnt, n_eff, hd, hd_eff;
  logic [MND_W:0]   sum;
  logic             wrap;

  assign n_eff   = ~n_inv + m_val;
  assign hd      = (~d_inv) >> 1;
  assign hd_eff  = (hd == '0) ? MND_W'(1) : hd;
  assign sum     = {1'b0, acc} + {1'b0, m_val};
  assign wrap    = sum >= {1'b0, n_eff};
  assign lvl_nxt = wrap || (hcnt != '0);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      acc  <= '0;
      hcnt <= '0;
    end else if (start) begin
      acc  <= wrap ? MND_W'(sum - {1'b0, n_eff}) : MND_W'(sum);
      if (wrap)              hcnt <= hd_eff - MND_W'(1);
      else if (hcnt != '0)   hcnt <= hcnt - MND_W'(1);
    end
  end

  // R8
  hold_bound_chk: assert property (@(posedge clk) disable iff (rst)
    hcnt < hd_eff);

endmodule

// File: rtl/mnd_root_clkgen.sv
module mnd_root_clkgen
  import mnd_clkgen_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3,
  parameter int MND_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               clk_out
);

  root_cfg_t        act_cfg;
  logic [MND_W-1:0] act_m, act_ninv, act_dinv;
  logic             apply, sel_tick, adv, pd_start, pd_lvl, acc_lvl, accum_en;
  logic [NUM_SRC-1:0] hit;

  mnd_clkgen_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MND_W(MND_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .out_low(!clk_out), .apply(apply),
    .act_cfg(act_cfg), .act_m(act_m), .act_ninv(act_ninv), .act_dinv(act_dinv)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_sel
    assign hit[s] = src_tick[s] && (32'(act_cfg.sel) == s);
  end

  assign sel_tick = |hit;
  assign adv      = sel_tick && !apply;
  assign accum_en = (act_cfg.mode == MODE_ACCUM) && (act_ninv != '0);

  mnd_clkgen_prediv u_prediv (
    .clk(clk), .rst(rst), .restart(apply), .tick(adv),
    .div_field(act_cfg.div), .start(pd_start), .lvl_nxt(pd_lvl)
  );

  mnd_clkgen_accum #(.MND_W(MND_W)) u_accum (
    .clk(clk), .rst(rst), .restart(apply), .start(pd_start),
    .m_val(act_m), .n_inv(act_ninv), .d_inv(act_dinv), .lvl_nxt(acc_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst)        clk_out <= 1'b0;
    else if (apply) clk_out <= 1'b0;
    else if (adv) begin
      if (accum_en) begin
        if (pd_start) clk_out <= acc_lvl;
      end else begin
        clk_out <= pd_lvl;
      end
    end
  end

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sel_tick |=> $stable(clk_out));

endmodule

// File: tb/test_mnd_root_clkgen.sv
module test_mnd_root_clkgen;

  localparam int NS = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] src_tick = '0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [2:0]    rd_addr = '0;
  logic [31:0]   rd_data;
  logic          clk_out;

  always #5 clk = ~clk;

  mnd_root_clkgen #(.NUM_SRC(NS)) i_mnd_root_clkgen (
    .clk(clk), .rst(rst), .src_tick(src_tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .clk_out(clk_out)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit exp_q[$];

  // shadow and active model state
  int s_src, s_P, s_M, s_N, s_H; bit s_acc;
  int a_src = 0, a_P = 2, a_M = 0, a_N = 0, a_H = 1; bit a_acc = 0;
  int k = 0;
  bit cur_exp = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: compares the output after every driven edge strobe
  always @(posedge clk) begin
    bit had;
    had = (src_tick != '0);
    #1;
    if (had) begin
      bit e;
      if (exp_q.size() == 0) chk(0, "R5 scoreboard empty", 0, 1);
      else begin
        e = exp_q.pop_front();
        chk(clk_out == e, "R5-R9 level", clk_out, e);
      end
    end
  end

  function automatic bit model_lvl(input int kk);
    int j;
    if (!a_acc) return (kk % a_P) < (a_P / 2);
    j = kk / a_P;
    for (int i = j; i >= 0 && i > j - a_H; i--)
      if (((i + 1) * a_M) / a_N > (i * a_M) / a_N) return 1'b1;
    return 1'b0;
  endfunction

  task automatic tick(input int s);
    @(negedge clk);
    src_tick = NS'(1 << s);
    if (s == a_src) begin
      cur_exp = model_lvl(k);
      k++;
    end
    exp_q.push_back(cur_exp);
    @(negedge clk);
    src_tick = '0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = 3'(a);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic prog(input logic [31:0] cfg, input logic [15:0] m,
                      input logic [15:0] ninv, input logic [15:0] dinv);
    logic [15:0] nn, hh;
    wr(1, cfg); wr(2, 32'(m)); wr(3, 32'(ninv)); wr(4, 32'(dinv));
    s_P   = (cfg[4:0] == 0) ? 2 : int'(cfg[4:0]) + 1;
    s_src = int'(cfg[10:8]);
    s_acc = (cfg[13:12] == 2'd2) && (ninv != 0);
    nn    = ~ninv + m;
    hh    = (~dinv) >> 1;
    s_M = int'(m); s_N = int'(nn); s_H = (hh == 0) ? 1 : int'(hh);
  endtask

  task automatic apply_model();
    a_src = s_src; a_P = s_P; a_acc = s_acc; a_M = s_M; a_N = s_N; a_H = s_H;
    k = 0; cur_exp = 0;
  endtask

  // waits for the command bit to clear, feeding edges while the output is high
  task automatic wait_done(input bit want_pend);
    logic [31:0] d;
    int it = 0;
    int bound = a_P * (a_H + 1) + 2;
    forever begin
      repeat (2) @(negedge clk);
      rd(0, d);
      if (it == 0 && want_pend) chk(d[0] == 1'b1, "R4 pending while high", int'(d[0]), 1);
      if (d[0] == 1'b0) break;
      tick(a_src);
      it++;
    end
    chk(it <= bound, "R4 bounded clear", it, bound);
    apply_model();
  endtask

  task automatic do_update(input bit want_pend);
    wr(0, 32'h1);
    wait_done(want_pend);
  endtask

  task automatic run_to_high();
    while (cur_exp != 1'b1) tick(a_src);
  endtask

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(clk_out == 1'b0, "R1 output low", int'(clk_out), 0);
    for (int a = 0; a < 5; a++) begin
      rd(a, d);
      chk(d == 0, "R1 register reset", int'(d), 0);
    end
    // R2 configuration width
    wr(1, 32'hFFFF_FFFF);
    rd(1, d);
    chk(d == 32'h3FFF, "R2 cfg readback", int'(d), 32'h3FFF);

    // R5 integer divide by 4 on source 1, with R6 foreign strobes mixed in
    prog(32'h0107, 16'h0, 16'h0, 16'hFFFF);
    do_update(0);
    for (int i = 0; i < 24; i++) begin
      tick(1);
      if (i % 5 == 2) tick(0);
      if (i % 7 == 3) tick(3);
    end

    // R3 shadow: new setting written, no update yet
    prog(32'h0002, 16'h0, 16'h0, 16'hFFFF);
    for (int i = 0; i < 10; i++) tick(1);
    // R4 and R9: update requested while output high
    run_to_high();
    do_update(1);
    // R5 half-integer divide (1.5) on source 0
    for (int i = 0; i < 15; i++) tick(0);

    // R5 divider field 0 acts as divide by 1
    prog(32'h0100, 16'h0, 16'h0, 16'hFFFF);
    do_update(0);
    for (int i = 0; i < 10; i++) tick(1);

    // R7 R8 accumulator mode: M=3 N=8 H=1, pre-divide 1
    prog(32'h2101, 16'd3, ~16'd5, ~16'd2);
    do_update(0);
    for (int i = 0; i < 48; i++) tick(1);

    // R7 R8 M=1 N=3 H=2, pre-divide 1.5; update with the falling edge in the same cycle
    prog(32'h2002, 16'd1, ~16'd2, ~16'd4);
    run_to_high();
    while (model_lvl(k) != 1'b0) tick(a_src);
    @(negedge clk);
    src_tick = NS'(1 << a_src);
    cur_exp = model_lvl(k); k++;
    exp_q.push_back(cur_exp);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'h1;
    @(negedge clk);
    src_tick = '0; wr_en = 1'b0;
    wait_done(0);
    for (int i = 0; i < 60; i++) tick(0);

    // R7 mode 2 with N register zero divides only
    prog(32'h2103, 16'd3, 16'h0, 16'hFFFF);
    do_update(0);
    for (int i = 0; i < 12; i++) tick(1);
    // R7 mode 1 with N nonzero divides only
    prog(32'h1103, 16'd3, ~16'd5, 16'hFFFF);
    do_update(0);
    for (int i = 0; i < 12; i++) tick(1);

    // R6 source field out of range stops the output
    prog(32'h0501, 16'h0, 16'h0, 16'hFFFF);
    do_update(0);
    for (int i = 0; i < 8; i++) tick(i % NS);
    chk(clk_out == 1'b0, "R6 stopped output", int'(clk_out), 0);

    // R4 command write with bit 0 clear is ignored
    wr(0, 32'h0);
    repeat (2) @(negedge clk);
    rd(0, d);
    chk(d[0] == 1'b0, "R4 clear write ignored", int'(d[0]), 0);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule